// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Divider Control

This block sits in the feedback path of a fractional-N synthesizer. It is clocked by the output of a dual-modulus prescaler, one clock per prescaler output pulse. It drives the prescaler's modulus select so that the total number of oscillator cycles per divided output cycle averages P·B + A + FN/M. P is the prescaler base ratio (8 or 6), B is the programmable count, A is the swallow count, FN is the fractional numerator and M is the fractional modulus. M is 1920 or 1968, chosen by the reference selection, so one unit of FN is always one 10 kHz step.

Each divided cycle lasts B prescaler clocks. During the first S of them the prescaler is told to divide by P+1, and during the rest by P. S is A, plus one when the first-order fractional accumulator wraps. The accumulator adds FN once per divided cycle and wraps at M. The settings are sampled only at the edge that closes a divided cycle. Settings outside their legal ranges are clamped, and a flag reports the clamp for the whole cycle that uses them.

Top module: `fracn_swallow_div`

## Requirements
- R1: While reset is asserted, modCtrl, divPulse and cfgErr are low. The first divided cycle after reset lasts 2 prescaler clocks with modCtrl low throughout.
- R2: Every divided cycle lasts exactly Beff prescaler clocks. divPulse is high for one clock only, and that clock is the last one of the cycle.
- R3: modCtrl high means divide by P+1. In each cycle modCtrl is high for the first S clocks, contiguously, and low for the rest. S = Aeff + carry.
- R4: At each cycle boundary the accumulator adds FNeff. When the sum reaches M, carry is 1 and M is subtracted. M is 1920 when refSel = 0 and 1968 when refSel = 1. The carry applies to the cycle that starts at that boundary.
- R5: Over M consecutive cycles with constant legal settings, the oscillator count sums to exactly M·(P·B + A) + FN. P is 8 when pscSel = 1 and 6 when pscSel = 0.
- R6: Beff = max(B, 2). Aeff = min(A, cap, Beff−1), where cap is 7 for P = 8 and 5 for P = 6. FNeff = M−1 when FN ≥ M, and FN otherwise.
- R7: cfgErr is high for the whole of a cycle whose sampled settings had B < 2, A ≥ B, A > cap or FN ≥ M. It is low for a cycle whose settings were all legal.
- R8: bWord, aWord, fnWord, pscSel and refSel are sampled only at the rising edge that ends a clock with divPulse high. Changes at any other time do not affect the cycle in progress.
- R9: When refSel differs from the value sampled at the previous boundary, the accumulator restarts from zero before FNeff is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock, one rising edge per prescaler pulse |
| rstN | input | 1 | Active-low asynchronous reset |
| bWord | input | 4 | Programmable count B |
| aWord | input | 3 | Swallow count A |
| fnWord | input | 11 | Fractional numerator FN |
| pscSel | input | 1 | 1: base ratio 8, 0: base ratio 6 |
| refSel | input | 1 | 0: modulus 1920, 1: modulus 1968 |
| modCtrl | output | 1 | 1: prescaler divides by P+1, 0: by P |
| divPulse | output | 1 | High during the last prescaler clock of each divided cycle |
| cfgErr | output | 1 | Settings used by the current cycle were clamped |

## Verification
Settings present at the rising edge that closes a divPulse clock take effect from the very next clock. That next clock carries the new cycle's first modCtrl value and its new cfgErr. The cycle's length, and the carry it gets from the accumulator, are complete only when its own divPulse clock is seen, Beff clocks later. The bench drives inputs 2 ns after a rising edge and samples outputs on the falling edge. At every divPulse it compares the clock and swallow counts just finished against a reference accumulator. That reference was updated from the inputs seen at the previous boundary. The long-run sums are taken between boundary counts M cycles apart, starting one boundary after new settings are applied.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  // Base-ratio choice of the dual-modulus prescaler.
  typedef enum logic {
    PSC_LOW  = 1'b0,  // base ratio 6
    PSC_HIGH = 1'b1   // base ratio 8
  } pscSel_e;

  // Strobes from the control sequencer to the datapath.
  typedef struct packed {
    logic cycleEnd;   // current clock is the last of a divided cycle
  } fsdStrobe_t;

endpackage

// File: rtl/fsd_clamp.sv
module fsd_clamp
  import fsd_pkg::*;
#(
  parameter int B_W      = 4,
  parameter int A_W      = 3,
  parameter int FN_W     = 11,
  parameter int B_MIN    = 2,
  parameter int MOD_LO   = 1920,
  parameter int MOD_HI   = 1968,
  parameter int A_CAP_HI = 7,
  parameter int A_CAP_LO = 5,
  localparam int ACC_W   = FN_W + 1
) (
  input  logic [B_W-1:0]   bIn,
  input  logic [A_W-1:0]   aIn,
  input  logic [FN_W-1:0]  fnIn,
  input  logic             pscSel,
  input  logic             refSel,
  output logic [B_W-1:0]   bEff,
  output logic [B_W-1:0]   aEff,
  output logic [FN_W-1:0]  fnEff,
  output logic [ACC_W-1:0] modulus,
  output logic             cfgBad
);

  localparam logic [B_W-1:0]   B_FLOOR = B_W'(B_MIN);
  localparam logic [B_W-1:0]   CAP_HI  = B_W'(A_CAP_HI);
  localparam logic [B_W-1:0]   CAP_LO  = B_W'(A_CAP_LO);
  localparam logic [ACC_W-1:0] MOD_L   = ACC_W'(MOD_LO);
  localparam logic [ACC_W-1:0] MOD_H   = ACC_W'(MOD_HI);

  logic [B_W-1:0]   aWide;
  logic [B_W-1:0]   capSel;
  logic [B_W-1:0]   bClamp;
  logic [B_W-1:0]   bLess;
  logic [B_W-1:0]   aLimit;
  logic [ACC_W-1:0] fnWide;

  always_comb begin
    modulus = refSel ? MOD_H : MOD_L;
    capSel  = (pscSel == PSC_HIGH) ? CAP_HI : CAP_LO;
    aWide   = B_W'(aIn);
    fnWide  = ACC_W'(fnIn);

    // Floor on the programmable count.
    bClamp  = (bIn < B_FLOOR) ? B_FLOOR : bIn;
    bLess   = bClamp - 1'b1;

    // Swallow limit: prescaler cap and strictly below the programmable count.
    aLimit  = (capSel < bLess) ? capSel : bLess;
    aEff    = (aWide > aLimit) ? aLimit : aWide;
    bEff    = bClamp;

    // Numerator held one step below the modulus.
    fnEff   = (fnWide >= modulus) ? FN_W'(modulus - 1'b1) : fnIn;

    cfgBad  = (bIn < B_FLOOR) | (aWide >= bIn) | (aWide > capSel) | (fnWide >= modulus);
  end

endmodule

// File: rtl/fsd_datapath.sv
module fsd_datapath
  import fsd_pkg::*;
#(
  parameter int B_W      = 4,
  parameter int A_W      = 3,
  parameter int FN_W     = 11,
  parameter int B_MIN    = 2,
  parameter int MOD_LO   = 1920,
  parameter int MOD_HI   = 1968,
  parameter int A_CAP_HI = 7,
  parameter int A_CAP_LO = 5,
  localparam int ACC_W   = FN_W + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  fsdStrobe_t      strobe,
  input  logic [B_W-1:0]  bWord,
  input  logic [A_W-1:0]  aWord,
  input  logic [FN_W-1:0] fnWord,
  input  logic            pscSel,
  input  logic            refSel,
  output logic [B_W-1:0]  bLast,
  output logic [B_W-1:0]  swallowCnt,
  output logic            cfgErr
);

  localparam logic [ACC_W-1:0] MOD_L = ACC_W'(MOD_LO);
  localparam logic [ACC_W-1:0] MOD_H = ACC_W'(MOD_HI);

  logic [B_W-1:0]   bEff;
  logic [B_W-1:0]   aEff;
  logic [FN_W-1:0]  fnEff;
  logic [ACC_W-1:0] modulus;
  logic             cfgBad;

  logic [B_W-1:0]   curB;
  logic [B_W-1:0]   curSwallow;
  logic [ACC_W-1:0] accReg;
  logic             curRef;

  logic [ACC_W-1:0] accBase;
  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] accNext;
  logic             carry;
  logic [B_W-1:0]   swallowNext;
  logic [ACC_W-1:0] curMod;

  fsd_clamp #(
    .B_W(B_W), .A_W(A_W), .FN_W(FN_W), .B_MIN(B_MIN),
    .MOD_LO(MOD_LO), .MOD_HI(MOD_HI),
    .A_CAP_HI(A_CAP_HI), .A_CAP_LO(A_CAP_LO)
  ) u_clamp (
    .bIn(bWord), .aIn(aWord), .fnIn(fnWord),
    .pscSel(pscSel), .refSel(refSel),
    .bEff(bEff), .aEff(aEff), .fnEff(fnEff),
    .modulus(modulus), .cfgBad(cfgBad)
  );

  // First-order accumulator step, restarting when the modulus changes.
  always_comb begin
    accBase     = (refSel != curRef) ? '0 : accReg;
    accSum      = accBase + ACC_W'(fnEff);
    carry       = (accSum >= modulus);
    accNext     = carry ? (accSum - modulus) : accSum;
    swallowNext = aEff + B_W'(carry);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curB       <= B_W'(B_MIN);
      curSwallow <= '0;
      accReg     <= '0;
      curRef     <= 1'b0;
      cfgErr     <= 1'b0;
    end else if (strobe.cycleEnd) begin
      curB       <= bEff;
      curSwallow <= swallowNext;
      accReg     <= accNext;
      curRef     <= refSel;
      cfgErr     <= cfgBad;
    end
  end

  assign bLast      = curB - 1'b1;
  assign swallowCnt = curSwallow;
  assign curMod     = curRef ? MOD_H : MOD_L;

  // R4: the residue always stays below the modulus it was reduced by.
  a_r4_acc_below_mod: assert property (@(posedge clk) disable iff (!rstN)
    accReg < curMod);

  // R6: the programmable count never drops under its floor.
  a_r6_b_floor: assert property (@(posedge clk) disable iff (!rstN)
    curB >= B_W'(B_MIN));

  // R3: the swallow portion fits inside the cycle.
  a_r3_swallow_fits: assert property (@(posedge clk) disable iff (!rstN)
    curSwallow <= curB);

  // R8: latched settings hold between boundaries.
  a_r8_hold_midcycle: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cycleEnd |=> ($stable(curB) && $stable(curSwallow) && $stable(cfgErr)));

endmodule

// File: rtl/fsd_ctrl.sv
module fsd_ctrl
  import fsd_pkg::*;
#(
  parameter int B_W = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [B_W-1:0] bLast,
  input  logic [B_W-1:0] swallowCnt,
  output fsdStrobe_t     strobe,
  output logic           modCtrl,
  output logic           divPulse
);

  logic [B_W-1:0] pulseIdx;

  always_comb begin
    strobe.cycleEnd = (pulseIdx == bLast);
    modCtrl         = (pulseIdx < swallowCnt);
    divPulse        = strobe.cycleEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                pulseIdx <= '0;
    else if (strobe.cycleEnd) pulseIdx <= '0;
    else                      pulseIdx <= pulseIdx + 1'b1;
  end

  // R2: the pulse index never runs past the last count of the cycle.
  a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rstN)
    pulseIdx <= bLast);

  // R2: divided pulse is one clock wide and never back to back.
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  // R2: a new cycle starts from its first count.
  a_r2_restart: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> (pulseIdx == '0));

  // R3: the P+1 phase can only begin right after a boundary.
  a_r3_swallow_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modCtrl) |-> $past(divPulse));

endmodule

// File: rtl/fracn_swallow_div.sv
module fracn_swallow_div
  import fsd_pkg::*;
#(
  parameter int B_W      = 4,
  parameter int A_W      = 3,
  parameter int FN_W     = 11,
  parameter int B_MIN    = 2,
  parameter int MOD_LO   = 1920,
  parameter int MOD_HI   = 1968,
  parameter int A_CAP_HI = 7,
  parameter int A_CAP_LO = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [B_W-1:0]  bWord,
  input  logic [A_W-1:0]  aWord,
  input  logic [FN_W-1:0] fnWord,
  input  logic            pscSel,
  input  logic            refSel,
  output logic            modCtrl,
  output logic            divPulse,
  output logic            cfgErr
);

  fsdStrobe_t     strobe;
  logic [B_W-1:0] bLast;
  logic [B_W-1:0] swallowCnt;

  fsd_ctrl #(.B_W(B_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .bLast(bLast), .swallowCnt(swallowCnt),
    .strobe(strobe), .modCtrl(modCtrl), .divPulse(divPulse)
  );

  fsd_datapath #(
    .B_W(B_W), .A_W(A_W), .FN_W(FN_W), .B_MIN(B_MIN),
    .MOD_LO(MOD_LO), .MOD_HI(MOD_HI),
    .A_CAP_HI(A_CAP_HI), .A_CAP_LO(A_CAP_LO)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .bWord(bWord), .aWord(aWord), .fnWord(fnWord),
    .pscSel(pscSel), .refSel(refSel),
    .bLast(bLast), .swallowCnt(swallowCnt), .cfgErr(cfgErr)
  );

endmodule

// File: tb/fracn_swallow_div_tb.sv
module fracn_swallow_div_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  bWord = 4'd5;
  logic [2:0]  aWord = 3'd1;
  logic [10:0] fnWord = 11'd0;
  logic        pscSel = 1'b1;
  logic        refSel = 1'b0;
  logic        modCtrl, divPulse, cfgErr;

  always #4 clk = ~clk;   // 125 MHz

  fracn_swallow_div u_dut (
    .clk(clk), .rstN(rstN), .bWord(bWord), .aWord(aWord), .fnWord(fnWord),
    .pscSel(pscSel), .refSel(refSel),
    .modCtrl(modCtrl), .divPulse(divPulse), .cfgErr(cfgErr)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int modOf(input bit r);
    return r ? 1968 : 1920;
  endfunction
  function automatic int pOf(input bit p);
    return p ? 8 : 6;
  endfunction
  function automatic int bEffOf(input int b);
    return (b < 2) ? 2 : b;
  endfunction
  function automatic int aEffOf(input int a, input int b, input bit p);
    int cap = p ? 7 : 5;
    int lim = (cap < bEffOf(b) - 1) ? cap : bEffOf(b) - 1;
    return (a > lim) ? lim : a;
  endfunction
  function automatic int fnEffOf(input int fn, input bit r);
    return (fn >= modOf(r)) ? modOf(r) - 1 : fn;
  endfunction
  function automatic bit errOf(input int b, input int a, input int fn, input bit p, input bit r);
    int cap = p ? 7 : 5;
    return (b < 2) || (a >= b) || (a > cap) || (fn >= modOf(r));
  endfunction

  // Reference model of the cycle in progress (reset state first).
  int     eB = 2, eSw = 0, eP = 8;
  bit     eErr = 1'b0;
  int     mAcc = 0;
  bit     mRef = 1'b0;
  longint totalVco = 0;
  longint vcoCyc = 0;
  int     bndCount = 0;
  int     clkCnt = 0, hiCnt = 0, lastLen = 0, lastHi = 0;
  bit     sawLow = 1'b0, patBad = 1'b0, monOn = 1'b0;

  always @(negedge clk) begin
    if (monOn) begin
      clkCnt++;
      vcoCyc += eP + int'(modCtrl);
      if (modCtrl) begin
        hiCnt++;
        if (sawLow) patBad = 1'b1;
      end else begin
        sawLow = 1'b1;
      end
      if (divPulse) begin
        int fnE, base, sum, mm;
        bit cy;
        check(clkCnt == eB, "R2 R6 R8 cycle length in prescaler clocks", clkCnt, eB);
        check(hiCnt == eSw && !patBad, "R3 R4 R9 leading P+1 clocks", hiCnt, eSw);
        check(cfgErr == eErr, "R7 clamp flag over cycle", cfgErr, eErr);
        totalVco += vcoCyc;
        lastLen = clkCnt;
        lastHi  = hiCnt;
        mm   = modOf(refSel);
        fnE  = fnEffOf(fnWord, refSel);
        base = (refSel != mRef) ? 0 : mAcc;
        sum  = base + fnE;
        cy   = (sum >= mm);
        mAcc = cy ? sum - mm : sum;
        mRef = refSel;
        eB   = bEffOf(bWord);
        eSw  = aEffOf(aWord, bWord, pscSel) + int'(cy);
        eP   = pOf(pscSel);
        eErr = errOf(bWord, aWord, fnWord, pscSel, refSel);
        clkCnt = 0; hiCnt = 0; sawLow = 1'b0; patBad = 1'b0; vcoCyc = 0;
        bndCount++;
      end
    end
  end

  task automatic setCfg(input int p, input int b, input int a, input int fn, input int r);
    @(posedge clk); #2;
    pscSel = p[0]; bWord = b[3:0]; aWord = a[2:0]; fnWord = fn[10:0]; refSel = r[0];
  endtask

  task automatic waitCycles(input int n);
    int n0 = bndCount;
    wait (bndCount >= n0 + n);
  endtask

  // R5: averaged ratio over exactly M cycles.
  task automatic longRun(input int p, input int b, input int a, input int fn, input int r);
    int     n1, mm;
    longint v0, expv;
    setCfg(p, b, a, fn, r);
    waitCycles(1);
    n1 = bndCount;
    v0 = totalVco;
    mm = modOf(r[0]);
    wait (bndCount == n1 + mm);
    expv = longint'(mm) * (pOf(p[0]) * b + a) + fn;
    check(totalVco - v0 == expv, "R5 oscillator count over M cycles", totalVco - v0, expv);
  endtask

  task automatic runTests();
    // R1: reset state
    repeat (3) @(negedge clk);
    check(modCtrl == 1'b0, "R1 modCtrl in reset", modCtrl, 0);
    check(divPulse == 1'b0, "R1 divPulse in reset", divPulse, 0);
    check(cfgErr == 1'b0, "R1 cfgErr in reset", cfgErr, 0);
    @(posedge clk); #2;
    rstN  = 1'b1;
    monOn = 1'b1;
    wait (bndCount == 1);
    check(lastLen == 2 && lastHi == 0, "R1 first cycle after reset", lastLen, 2);
    waitCycles(3);

    // Directed corners: whole cycle at P+1, clamps, floors
    setCfg(1, 3, 2, 1919, 0); waitCycles(6);
    setCfg(1, 0, 7, 2047, 0); waitCycles(2);
    @(negedge clk);
    check(cfgErr == 1'b1, "R7 flag for B under floor", cfgErr, 1);
    setCfg(0, 15, 7, 100, 1); waitCycles(3);
    setCfg(1, 4, 6, 5, 0); waitCycles(3);
    setCfg(1, 6, 2, 0, 0); waitCycles(2);
    @(negedge clk);
    check(cfgErr == 1'b0, "R7 flag clear for legal settings", cfgErr, 0);
    // R9: modulus switches with a large residue
    setCfg(0, 9, 3, 1967, 1); waitCycles(5);
    setCfg(0, 9, 3, 1900, 0); waitCycles(5);
    setCfg(1, 7, 1, 1500, 1); waitCycles(4);
    // R8: change settings mid-cycle, then restore before the boundary
    setCfg(1, 15, 3, 700, 0); waitCycles(1);
    repeat (3) @(posedge clk);
    #2; bWord = 4'd2; aWord = 3'd0; fnWord = 11'd3; pscSel = 1'b0;
    repeat (3) @(posedge clk);
    #2; bWord = 4'd15; aWord = 3'd3; fnWord = 11'd700; pscSel = 1'b1;
    waitCycles(3);

    // R5: long-run averages
    longRun(1, 2, 1, 1919, 0);
    longRun(0, 15, 5, 1967, 1);
    longRun(1, 9, 4, 1104, 0);
    longRun(1, 11, 2, 1680, 1);
    longRun(0, 9, 3, 1404, 1);
    longRun(1, 5, 0, 0, 0);

    // Random settings changed at arbitrary clocks (R6 R7 R8 R9)
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); #2;
      if ($urandom % 5 == 0) begin
        bWord  = 4'($urandom);
        aWord  = 3'($urandom);
        fnWord = ($urandom % 4 == 0) ? 11'($urandom) : 11'($urandom % 1920);
        pscSel = 1'($urandom);
        refSel = ($urandom % 8 == 0) ? ~refSel : refSel;
      end
    end
    setCfg(1, 4, 1, 10, 0);
    waitCycles(2);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule